// File: doc/BRIEF.md
# Bidirectional Sampling Strobe Chain

This block drives the column-sampling strobes of a display source driver. A start pulse enters from one end of the chain, and the scan runs across a configurable number of columns (240 by default). A direction input picks which end that is. Every column has one strobe output. While a column's strobe is high, that column takes in its video input. When the scan passes the last column, the block sends a cascade start pulse out of the opposite end, so the next driver in a row of drivers can begin its own scan.

The block has two scan modes. In the grouped mode, used for stripe-arranged panels, only phase clock 1 counts. Each rising edge of phase 1 moves a window of three adjacent strobes along the chain. In the sequential mode, used for delta and mosaic panels, a three-phase clock is applied. The rising edges of phases 1, 2 and 3 each move a single strobe on by one column. The phase clocks and the cascade inputs are slow signals. A fast system clock samples them and detects their rising edges.

Top module: `sample_strobe_chain`

## Requirements
- R1: After reset, every strobe is low and both cascade data outputs are low.
- R2: In grouped mode (`simulMode`=1), a phase 1 rise that captures a start pulse sets the first three logical columns high together. Each later phase 1 rise moves the three-wide window on by three columns.
- R3: In sequential mode (`simulMode`=0), the start capture sets only the first logical column. Each later rise of phase 1, 2 or 3 moves that single strobe on by one column.
- R4: When `dirRight`=1, logical column k maps to `strobe[k]`, the start is taken from `endRIn`, and the cascade pulse leaves on `endLOut`. When `dirRight`=0, logical column k maps to `strobe[N-1-k]`, the start is taken from `endLIn`, and the cascade pulse leaves on `endROut`.
- R5: Only the output-side pin of the cascade pair has its enable high: `endLOe`=`dirRight` and `endROe`=!`dirRight`. A pulse on the output-side input starts nothing.
- R6: The start level is looked at only on a phase 1 rise. A new start pulse during a scan returns the strobes to the first logical column.
- R7: In grouped mode, rises on phases 2 and 3 change neither the strobes nor the cascade output.
- R8: The step after the last column clears every strobe and raises the cascade output. The cascade output then stays high until the next step event, which clears it.
- R9: A start input that stays high across several phase 1 rises triggers only once, at the first rise.
- R10: A phase rise driven onto the pins changes the outputs at the second system clock edge after it. Between step events the outputs hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the phase and cascade inputs |
| rstN | input | 1 | Asynchronous active-low reset |
| dirRight | input | 1 | 1: scan runs from column 0 upward; 0: scan runs downward |
| simulMode | input | 1 | 1: grouped three-wide strobes on phase 1; 0: single strobe on three phases |
| ph1 | input | 1 | Phase clock 1; also the start-capture clock |
| ph2 | input | 1 | Phase clock 2 (sequential mode only) |
| ph3 | input | 1 | Phase clock 3 (sequential mode only) |
| endRIn | input | 1 | Right-end cascade pin, input value |
| endROut | output | 1 | Right-end cascade pin, driven value |
| endROe | output | 1 | Right-end cascade pin, drive enable |
| endLIn | input | 1 | Left-end cascade pin, input value |
| endLOut | output | 1 | Left-end cascade pin, driven value |
| endLOe | output | 1 | Left-end cascade pin, drive enable |
| strobe | output | STAGES | One sampling strobe per column |

## Verification
A phase or start level driven on a falling clock edge is registered at the next rising edge. The edge detector then acts at the rising edge after that, so a result is due two rising edges after the stimulus. The direct latency test samples at the falling edge after the first rising edge and expects no change. It samples again at the falling edge after the second rising edge and expects the new strobe pattern. Every other check waits three falling edges with the phase high and three with it low, and only then reads the strobe vector and the cascade pins. By that point the result for the step has settled and no later event is pending.

// File: rtl/sstrb_pkg.sv
package sstrb_pkg;
  // columns lit together in grouped mode, also the number of phase clocks
  localparam int GROUP_W = 3;

  typedef struct packed {
    logic restart;  // fresh start captured on a phase 1 rise
    logic advance;  // step event for the current mode
    logic wide;     // grouped three-wide stepping
  } stepCmd_t;
endpackage

// File: rtl/strobe_ctrl.sv
module strobe_ctrl
  import sstrb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     simulMode,
  input  logic     dirRight,
  input  logic     ph1,
  input  logic     ph2,
  input  logic     ph3,
  input  logic     endRIn,
  input  logic     endLIn,
  output stepCmd_t cmd
);
  logic [GROUP_W-1:0] phQ, phQQ, phRise;
  logic startQ, startSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phQ       <= '0;
      phQQ      <= '0;
      startQ    <= 1'b0;
      startSeen <= 1'b0;
    end else begin
      phQ    <= {ph3, ph2, ph1};
      phQQ   <= phQ;
      startQ <= dirRight ? endRIn : endLIn;
      if (phRise[0]) startSeen <= startQ;
    end
  end

  assign phRise      = phQ & ~phQQ;
  assign cmd.wide    = simulMode;
  assign cmd.restart = phRise[0] & startQ & ~startSeen;
  assign cmd.advance = simulMode ? phRise[0] : |phRise;

  // R7: in grouped mode a lone phase 2/3 rise is no step
  p_ph23_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (simulMode && !phRise[0]) |-> !cmd.advance);

  // R9: a start level already seen at the previous phase 1 rise never retriggers
  p_stretch_once_r9: assert property (@(posedge clk) disable iff (!rstN)
    (startSeen && phRise[0]) |-> !cmd.restart);

  // R6: restart only ever comes with a phase 1 rise
  p_start_on_ph1_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.restart |-> (phQ[0] && !phQQ[0]));
endmodule

// File: rtl/strobe_path.sv
module strobe_path
  import sstrb_pkg::*;
#(
  parameter int STAGES = 240
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCmd_t          cmd,
  input  logic              dirRight,
  output logic [STAGES-1:0] strobe,
  output logic              done
);
  localparam int POS_W = $clog2(STAGES);
  localparam logic [POS_W-1:0] LAST_ONE = POS_W'(STAGES - 1);
  localparam logic [POS_W-1:0] LAST_GRP = POS_W'(STAGES - GROUP_W);

  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  stepAmt;
  logic              active;
  logic              endNow;
  logic [STAGES-1:0] logical;

  if (STAGES % GROUP_W != 0) begin : g_bad_len
    initial $error("STAGES must be a multiple of the group width");
  end

  assign stepAmt = cmd.wide ? POS_W'(GROUP_W) : POS_W'(1);
  assign endNow  = cmd.wide ? (pos >= LAST_GRP) : (pos >= LAST_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos    <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else if (cmd.restart) begin
      pos    <= '0;
      active <= 1'b1;
      done   <= 1'b0;
    end else if (cmd.advance) begin
      done <= 1'b0;
      if (active) begin
        if (endNow) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          pos <= pos + stepAmt;
        end
      end
    end
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_col
    assign logical[i] = active &&
      (cmd.wide ? (i >= int'(pos) && i < int'(pos) + GROUP_W) : (i == int'(pos)));
    assign strobe[i] = dirRight ? logical[i] : logical[STAGES-1-i];
  end

  // R6: a captured start lands on the first logical column
  p_restart_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.restart |=> (active && pos == '0));

  // R8: cascade pulse lasts one step interval only
  p_cas_one_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && cmd.advance && !cmd.restart) |=> !done);

  // R2: never more than one group lit
  p_group_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(logical) <= GROUP_W);

  // R3: sequential mode lights at most one column
  p_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.wide |-> $onehot0(logical));

  // R10: no step event, no state change
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.advance && !cmd.restart) |=> ($stable(pos) && $stable(active) && $stable(done)));
endmodule

// File: rtl/sample_strobe_chain.sv
module sample_strobe_chain
  import sstrb_pkg::*;
#(
  parameter int STAGES = 240
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirRight,
  input  logic              simulMode,
  input  logic              ph1,
  input  logic              ph2,
  input  logic              ph3,
  input  logic              endRIn,
  output logic              endROut,
  output logic              endROe,
  input  logic              endLIn,
  output logic              endLOut,
  output logic              endLOe,
  output logic [STAGES-1:0] strobe
);
  stepCmd_t cmd;
  logic     done;

  strobe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .simulMode(simulMode), .dirRight(dirRight),
    .ph1(ph1), .ph2(ph2), .ph3(ph3), .endRIn(endRIn), .endLIn(endLIn),
    .cmd(cmd)
  );

  strobe_path #(.STAGES(STAGES)) u_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .dirRight(dirRight),
    .strobe(strobe), .done(done)
  );

  assign endLOe  = dirRight;
  assign endROe  = ~dirRight;
  assign endLOut = dirRight & done;
  assign endROut = ~dirRight & done;
endmodule

// File: tb/sim_sample_strobe_chain.sv
`timescale 1ns/1ps
module sim_sample_strobe_chain;
  localparam int N = 240;

  logic clk = 1'b0;
  logic rstN, dirRight, simulMode, endRIn, endLIn;
  logic [2:0] ph;
  logic endROut, endROe, endLOut, endLOe;
  logic [N-1:0] strobe;
  int vectors = 0;
  int miss = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sample_strobe_chain u0 (
    .clk(clk), .rstN(rstN), .dirRight(dirRight), .simulMode(simulMode),
    .ph1(ph[0]), .ph2(ph[1]), .ph3(ph[2]),
    .endRIn(endRIn), .endROut(endROut), .endROe(endROe),
    .endLIn(endLIn), .endLOut(endLOut), .endLOe(endLOe),
    .strobe(strobe)
  );

  function automatic logic [N-1:0] expv(int first, bit wide, bit right);
    logic [N-1:0] v = '0;
    if (first >= 0)
      for (int k = 0; k < (wide ? 3 : 1); k++) begin
        int c = first + k;
        if (!right) c = N - 1 - c;
        v[c] = 1'b1;
      end
    return v;
  endfunction

  task automatic chkV(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    vectors++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s strobe got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic chkB(string tag, logic got, logic exp);
    vectors++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic step(int which);
    @(negedge clk) ph[which] = 1'b1;
    repeat (3) @(negedge clk);
    ph[which] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    rstN = 1'b0; dirRight = 1'b1; simulMode = 1'b1;
    endRIn = 1'b0; endLIn = 1'b0; ph = '0;
    repeat (4) @(negedge clk);
    chkV("R1 reset strobes", strobe, '0);
    chkB("R1 reset endLOut", endLOut, 1'b0);
    chkB("R1 reset endROut", endROut, 1'b0);
    chkB("R5 endLOe right", endLOe, 1'b1);
    chkB("R5 endROe right", endROe, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_wrong_side;
    dirRight = 1'b1; simulMode = 1'b1;
    endLIn = 1'b1;
    step(0);
    endLIn = 1'b0;
    chkV("R5 output-side input ignored", strobe, '0);
  endtask

  task automatic t_simul_right;
    dirRight = 1'b1; simulMode = 1'b1;
    @(negedge clk) begin endRIn = 1'b1; ph[0] = 1'b1; end
    @(negedge clk);
    chkV("R10 one edge: no change yet", strobe, '0);
    @(negedge clk);
    chkV("R10 R2 first group after two edges", strobe, expv(0, 1, 1));
    @(negedge clk) ph[0] = 1'b0;
    repeat (3) @(negedge clk);
    endRIn = 1'b0;
    step(0);
    chkV("R2 second group", strobe, expv(3, 1, 1));
    step(1);
    step(2);
    chkV("R7 ph2/ph3 ignored", strobe, expv(3, 1, 1));
    for (int g = 2; g < N / 3; g++) step(0);
    chkV("R2 last group", strobe, expv(N - 3, 1, 1));
    step(0);
    chkV("R8 strobes clear after end", strobe, '0);
    chkB("R8 R4 cascade on left", endLOut, 1'b1);
    chkB("R4 no cascade on right", endROut, 1'b0);
    step(1);
    chkB("R7 R8 ph2 leaves cascade high", endLOut, 1'b1);
    step(0);
    chkB("R8 cascade clears next step", endLOut, 1'b0);
  endtask

  task automatic t_succ_left;
    dirRight = 1'b0; simulMode = 1'b0;
    repeat (2) @(negedge clk);
    chkB("R5 endROe left", endROe, 1'b1);
    chkB("R5 endLOe left", endLOe, 1'b0);
    endLIn = 1'b1;
    step(1);
    chkV("R6 start not taken on ph2", strobe, '0);
    step(0);
    endLIn = 1'b0;
    chkV("R4 R3 left start at top column", strobe, expv(0, 0, 0));
    for (int k = 1; k < N; k++) begin
      step(k % 3);
      if (k == 1) chkV("R3 ph2 step", strobe, expv(1, 0, 0));
      if (k == 2) chkV("R3 ph3 step", strobe, expv(2, 0, 0));
      if (k == 3) chkV("R3 ph1 step", strobe, expv(3, 0, 0));
    end
    chkV("R3 R4 last column is 0", strobe, expv(N - 1, 0, 0));
    step(N % 3);
    chkV("R8 clear after end left", strobe, '0);
    chkB("R4 R8 cascade on right", endROut, 1'b1);
    chkB("R4 no cascade on left", endLOut, 1'b0);
    step((N + 1) % 3);
    chkB("R8 right cascade clears", endROut, 1'b0);
  endtask

  task automatic t_stretch_restart;
    dirRight = 1'b1; simulMode = 1'b1;
    endRIn = 1'b1;
    step(0);
    step(0);
    endRIn = 1'b0;
    chkV("R9 stretched start no retrigger", strobe, expv(3, 1, 1));
    step(0);
    chkV("R2 third group", strobe, expv(6, 1, 1));
    endRIn = 1'b1;
    step(0);
    endRIn = 1'b0;
    chkV("R6 mid-scan restart", strobe, expv(0, 1, 1));
    step(0);
    chkV("R6 continues after restart", strobe, expv(3, 1, 1));
  endtask

  initial begin
    t_reset();
    t_wrong_side();
    t_simul_right();
    t_succ_left();
    t_stretch_restart();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end
endmodule